// File: doc/BRIEF.md
# Transmit Outcome Status and Statistics Unit

This block sits beside the transmit engine of a small Ethernet MAC and keeps the record of how each frame ended. The engine reports each outcome as a one-cycle pulse on a 16-bit event vector. The unit gathers those pulses into a sticky status word. It counts collisions and deferrals in four packed 4-bit counters. It tracks the link state, and it raises one event interrupt request from three causes, each with its own enable.

A transmit outcome can be fatal: sixteen collisions, SQE test failure, late collision or lost carrier. Any of these drops the transmit-enable bit without help from software, and the unit gives a one-cycle indication that it did so. Software re-arms the transmitter by writing the enable bit again. Reading the counter word returns its value and clears it. Reading the status word returns its sticky bits and clears them. A link-loss interrupt is acknowledged by writing the link-error enable to zero and then setting it again.

Top module: `txstat_unit`

## Requirements
- R1: After reset, status_word, count_word, tx_en, tx_en_clr and evt_irq are all zero.
- R2: An event pulse on tx_evt bit n, for n in {0..7, 9, 10, 11, 13, 15}, sets status_word bit n from the next cycle, and the bit stays set. Pulses on tx_evt bits 8, 12 and 14 have no effect. A read of address 1 returns the status word and clears these sticky bits. Event pulses in the same cycle as that read are lost.
- R3: status_word bit 14 equals the link_ok input delayed by one clock cycle.
- R4: A pulse on tx_evt bit 4, 5, 9 or 10 (fatal events) makes tx_en 0 on the next cycle, even when tx_en is written to 1 in the same cycle. tx_en_clr is high for exactly the cycle after each cycle that carries a fatal pulse.
- R5: A write to address 0 loads tx_en from reg_wdata bit 0. This write re-arms the transmitter after a fatal event.
- R6: count_word nibble [3:0] counts pulses on tx_evt bit 1. Nibble [7:4] counts bit 2, nibble [11:8] counts bit 7, and nibble [15:12] counts bit 11. Each pulse adds one on the next cycle.
- R7: A nibble counter that steps from 15 to 0 sets status_word bit 12. That bit is not cleared by a status read.
- R8: A read of address 2 returns count_word and clears all four nibbles and status_word bit 12 on the next cycle. Increments in the same cycle as the read are lost.
- R9: evt_irq is high when any of the following holds:
  - control bit 5 is set and any of status bits 4, 5, 9, 10 is set;
  - control bit 6 is set and status bit 12 is set;
  - control bit 7 is set and a link-error is pending.
- R10: A link-error becomes pending when status bit 14 falls. A write of address 3 with bit 7 clear removes the pending link-error. Setting bit 7 again does not restore it.
- R11: reg_rdata holds the register at reg_addr, for the following addresses:
  - address 0: tx_en in bit 0;
  - address 1: status_word;
  - address 2: count_word;
  - address 3: the control bits 7:5, with all other bits 0.

  Writes to addresses 1 and 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_evt | input | 16 | One-cycle outcome pulses, bit positions as in the status word |
| link_ok | input | 1 | Link state level from the PHY |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| status_word | output | 16 | Protocol-handler status word |
| count_word | output | 16 | Four packed nibble statistics counters |
| tx_en | output | 1 | Transmit enable |
| tx_en_clr | output | 1 | Pulse: a fatal event just cleared transmit enable |
| evt_irq | output | 1 | Event interrupt request |

## Verification
A sticky bit that is wrong inside the unit shows on status_word on the very next cycle. Because the status word is exported every cycle, a missed clear or a spurious set is caught within one clock. A counter that steps wrongly diverges in count_word at once. Its fault also spreads to bit 12 and to evt_irq only when the counter wraps, so long runs of collision pulses are needed to expose rollover faults. A stale pending link-error or control bit stays hidden until its enable is set, and then it appears on evt_irq in the same cycle.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
   localparam int STAT_W    = 16;
   localparam int ROLL_BIT  = 12;
   localparam int LINK_BIT  = 14;
   // fatal outcomes: sixteen collisions, SQE fail, late collision, lost carrier
   localparam logic [STAT_W-1:0] FATAL_MASK  = 16'h0630;
   // sticky event bits (excludes 8, rollover 12, link 14)
   localparam logic [STAT_W-1:0] STICKY_MASK = 16'hAEFF;

   typedef enum logic [1:0] {
      A_TXCTL = 2'd0,
      A_STAT  = 2'd1,
      A_CNT   = 2'd2,
      A_CTL   = 2'd3
   } reg_addr_e;

   // event bit feeding each nibble counter
   function automatic int cnt_src(input int idx);
      case (idx)
         0: cnt_src = 1;
         1: cnt_src = 2;
         2: cnt_src = 7;
         default: cnt_src = 11;
      endcase
   endfunction
endpackage

// File: rtl/txstat_ctr.sv
module txstat_ctr #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         clr,
   output logic [W-1:0] cnt,
   output logic         wrap
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   if (W < 2) begin : g_bad_w
      $error("txstat_ctr: W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end

   assign wrap = inc && !clr && (cnt == TOP);

   // R6
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inc && !clr |=> cnt == W'($past(cnt) + 1));
   // R8
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0);
endmodule

// File: rtl/txstat_flags.sv
module txstat_flags
   import txstat_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] tx_evt,
   input  logic              st_rd,
   input  logic              cnt_rd,
   input  logic              any_wrap,
   output logic [STAT_W-1:0] flags
);
   logic [STAT_W-1:0] sticky_q;
   logic              roll_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     sticky_q <= '0;
      else if (st_rd) sticky_q <= '0;
      else            sticky_q <= sticky_q | (tx_evt & STICKY_MASK);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        roll_q <= 1'b0;
      else if (cnt_rd)   roll_q <= 1'b0;
      else if (any_wrap) roll_q <= 1'b1;
   end

   always_comb begin
      flags           = sticky_q;
      flags[ROLL_BIT] = roll_q;
   end

   // R2
   st_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_rd |=> (flags & STICKY_MASK) == '0);
   // R7
   roll_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_wrap && !cnt_rd |=> flags[ROLL_BIT]);
   // R8
   roll_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rd |=> !flags[ROLL_BIT]);
endmodule

// File: rtl/txstat_txctl.sv
module txstat_txctl
   import txstat_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] tx_evt,
   input  logic              link_ok,
   input  logic              wr_txctl,
   input  logic              wr_ctl,
   input  logic              wd_txen,
   input  logic [2:0]        wd_ctl,
   input  logic              fatal_pend,
   input  logic              roll_pend,
   output logic              tx_en,
   output logic              tx_en_clr,
   output logic [2:0]        ctl,
   output logic              link_q,
   output logic              evt_irq
);
   logic fatal_now;
   logic link_fall;
   logic lpend_q;

   assign fatal_now = |(tx_evt & FATAL_MASK);
   assign link_fall = link_q && !link_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_en     <= 1'b0;
         tx_en_clr <= 1'b0;
         ctl       <= '0;
         link_q    <= 1'b0;
         lpend_q   <= 1'b0;
      end else begin
         tx_en_clr <= fatal_now;
         link_q    <= link_ok;
         if (fatal_now)     tx_en <= 1'b0;
         else if (wr_txctl) tx_en <= wd_txen;
         if (wr_ctl) ctl <= wd_ctl;
         if (link_fall)                lpend_q <= 1'b1;
         else if (wr_ctl && !wd_ctl[2]) lpend_q <= 1'b0;
      end
   end

   assign evt_irq = (ctl[0] && fatal_pend) || (ctl[1] && roll_pend)
                 || (ctl[2] && lpend_q);

   // R4
   fatal_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fatal_now |=> !tx_en && tx_en_clr);
   // R5
   rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_txctl && wd_txen && !fatal_now |=> tx_en);
   // R10
   link_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctl && !wd_ctl[2] && !link_fall |=> !lpend_q);
   // R10
   link_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      link_fall |=> lpend_q);
endmodule

// File: rtl/txstat_unit.sv
module txstat_unit
   import txstat_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int CNT_W   = 4,
   parameter int NUM_CNT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] tx_evt,
   input  logic              link_ok,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [DATA_W-1:0] status_word,
   output logic [DATA_W-1:0] count_word,
   output logic              tx_en,
   output logic              tx_en_clr,
   output logic              evt_irq
);
   localparam int PACK_W = CNT_W * NUM_CNT;

   if (DATA_W != STAT_W) begin : g_bad_data_w
      $error("txstat_unit: DATA_W must equal the status layout width");
   end
   if (PACK_W != DATA_W) begin : g_bad_pack
      $error("txstat_unit: counters must fill the counter word exactly");
   end

   logic              st_rd, cnt_rd, wr_txctl, wr_ctl;
   logic [NUM_CNT-1:0] wraps;
   logic [DATA_W-1:0] flags;
   logic [2:0]        ctl;
   logic              link_q;
   logic              unused_wd;

   assign st_rd    = reg_rd && (reg_addr == A_STAT);
   assign cnt_rd   = reg_rd && (reg_addr == A_CNT);
   assign wr_txctl = reg_wr && (reg_addr == A_TXCTL);
   assign wr_ctl   = reg_wr && (reg_addr == A_CTL);
   assign unused_wd = ^{reg_wdata[DATA_W-1:8], reg_wdata[4:1]};

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      txstat_ctr #(.W(CNT_W)) u_ctr (
         .clk   (clk),
         .rst_n (rst_n),
         .inc   (tx_evt[cnt_src(i)]),
         .clr   (cnt_rd),
         .cnt   (count_word[i*CNT_W +: CNT_W]),
         .wrap  (wraps[i])
      );
   end

   txstat_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .tx_evt   (tx_evt),
      .st_rd    (st_rd),
      .cnt_rd   (cnt_rd),
      .any_wrap (|wraps),
      .flags    (flags)
   );

   txstat_txctl u_txctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_evt     (tx_evt),
      .link_ok    (link_ok),
      .wr_txctl   (wr_txctl),
      .wr_ctl     (wr_ctl),
      .wd_txen    (reg_wdata[0]),
      .wd_ctl     (reg_wdata[7:5]),
      .fatal_pend (|(flags & FATAL_MASK)),
      .roll_pend  (flags[ROLL_BIT]),
      .tx_en      (tx_en),
      .tx_en_clr  (tx_en_clr),
      .ctl        (ctl),
      .link_q     (link_q),
      .evt_irq    (evt_irq)
   );

   always_comb begin
      status_word           = flags;
      status_word[LINK_BIT] = link_q;
   end

   always_comb begin
      unique case (reg_addr)
         A_TXCTL: reg_rdata = {{(DATA_W-1){1'b0}}, tx_en};
         A_STAT:  reg_rdata = status_word;
         A_CNT:   reg_rdata = count_word;
         default: reg_rdata = {{(DATA_W-8){1'b0}}, ctl, 5'b0};
      endcase
   end

   // R3
   link_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(link_ok) |=> status_word[LINK_BIT]);
   // R9
   irq_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl[1] && status_word[ROLL_BIT] |-> evt_irq);
endmodule

// File: tb/txstat_unit_bench.sv
module txstat_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] tx_evt = '0;
   logic        link_ok = 1'b0;
   logic        reg_rd = 1'b0, reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata, status_word, count_word;
   logic        tx_en, tx_en_clr, evt_irq;

   int checks = 0, errors = 0;

   // model state
   logic [15:0] m_stk;
   logic        m_roll, m_txen, m_clr, m_linkq, m_lpend;
   logic [3:0]  m_cnt [4];
   logic [2:0]  m_ctl;

   always #10 clk = ~clk;

   txstat_unit u_txstat_unit (
      .clk(clk), .rst_n(rst_n), .tx_evt(tx_evt), .link_ok(link_ok),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .status_word(status_word), .count_word(count_word),
      .tx_en(tx_en), .tx_en_clr(tx_en_clr), .evt_irq(evt_irq)
   );

   function automatic int src_of(input int i);
      case (i) 0: return 1; 1: return 2; 2: return 7; default: return 11; endcase
   endfunction

   function automatic logic [15:0] m_status();
      logic [15:0] s = m_stk;
      s[12] = m_roll;
      s[14] = m_linkq;
      return s;
   endfunction

   function automatic logic [15:0] m_count();
      return {m_cnt[3], m_cnt[2], m_cnt[1], m_cnt[0]};
   endfunction

   function automatic logic m_irq();
      return (m_ctl[0] && |(m_stk & 16'h0630)) || (m_ctl[1] && m_roll)
          || (m_ctl[2] && m_lpend);
   endfunction

   function automatic logic [15:0] m_rdata(input logic [1:0] a);
      case (a)
         2'd0: return {15'b0, m_txen};
         2'd1: return m_status();
         2'd2: return m_count();
         default: return {8'b0, m_ctl, 5'b0};
      endcase
   endfunction

   task automatic m_reset();
      m_stk = '0; m_roll = 0; m_txen = 0; m_clr = 0; m_linkq = 0;
      m_lpend = 0; m_ctl = '0;
      for (int i = 0; i < 4; i++) m_cnt[i] = '0;
   endtask

   task automatic m_update(input logic [15:0] e, input logic rd, input logic wr,
                           input logic [1:0] a, input logic [15:0] wd,
                           input logic lk);
      logic fatal = |(e & 16'h0630);
      if (rd && a == 2'd1) m_stk = '0;               // R2
      else m_stk = m_stk | (e & 16'hAEFF);
      if (rd && a == 2'd2) begin                     // R8
         for (int i = 0; i < 4; i++) m_cnt[i] = '0;
         m_roll = 0;
      end else begin
         for (int i = 0; i < 4; i++)
            if (e[src_of(i)]) begin
               if (m_cnt[i] == 4'hF) m_roll = 1;     // R7
               m_cnt[i] = m_cnt[i] + 4'd1;
            end
      end
      if (fatal) m_txen = 0;                         // R4
      else if (wr && a == 2'd0) m_txen = wd[0];      // R5
      m_clr = fatal;
      if (m_linkq && !lk) m_lpend = 1;               // R10
      else if (wr && a == 2'd3 && !wd[7]) m_lpend = 0;
      if (wr && a == 2'd3) m_ctl = wd[7:5];
      m_linkq = lk;                                  // R3
   endtask

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step(input logic [15:0] e, input logic rd, input logic wr,
                       input logic [1:0] a, input logic [15:0] wd, input logic lk);
      tx_evt = e; reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
      link_ok = lk;
      #1;
      if (rd) chk("R11 rdata", reg_rdata, m_rdata(a));
      @(posedge clk);
      m_update(e, rd, wr, a, wd, lk);
      @(negedge clk);
      tx_evt = '0; reg_rd = 0; reg_wr = 0;
      chk("R2 status", status_word, m_status());
      chk("R6 count", count_word, m_count());
      chk("R4 tx_en", {15'b0, tx_en}, {15'b0, m_txen});
      chk("R4 tx_en_clr", {15'b0, tx_en_clr}, {15'b0, m_clr});
      chk("R9 irq", {15'b0, evt_irq}, {15'b0, m_irq()});
   endtask

   task automatic idle(input logic lk);
      step('0, 0, 0, 2'd0, '0, lk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] e, wd;
      logic rd, wr, lk;
      logic [1:0] a;
      int seed_dummy;
      m_reset();
      seed_dummy = $urandom(32'h5EED1);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 status", status_word, 16'h0000);
      chk("R1 count", count_word, 16'h0000);
      chk("R1 outs", {13'b0, tx_en, tx_en_clr, evt_irq}, 16'h0000);

      // R5 arm transmitter
      step('0, 0, 1, 2'd0, 16'h0001, 0);
      chk("R5 tx_en armed", {15'b0, tx_en}, 16'h0001);
      // R4 fatal (late collision) clears it, pulse one cycle
      step(16'h0200, 0, 0, 2'd0, '0, 0);
      chk("R4 cleared", {14'b0, tx_en, tx_en_clr}, 16'h0001);
      idle(0);
      chk("R4 pulse ends", {15'b0, tx_en_clr}, 16'h0000);
      // R4 fatal wins over same-cycle write
      step(16'h0010, 0, 1, 2'd0, 16'h0001, 0);
      chk("R4 override", {15'b0, tx_en}, 16'h0000);
      step('0, 0, 1, 2'd0, 16'h0001, 0);
      chk("R5 rearm", {15'b0, tx_en}, 16'h0001);
      // R2 ignored bits and read clear
      step(16'h0001, 1, 0, 2'd1, '0, 0);   // event lost under read
      step(16'h5100, 0, 0, 2'd0, '0, 0);
      chk("R2 ignored bits", status_word, 16'h0000);
      step(16'h8008, 0, 0, 2'd0, '0, 0);
      chk("R2 sticky", status_word, 16'h8008);
      step('0, 1, 0, 2'd1, '0, 0);
      chk("R2 read clear", status_word, 16'h0000);
      // R3 link
      idle(1);
      chk("R3 link", {15'b0, status_word[14]}, 16'h0001);
      // R11 writes to status/counter ignored, control readback
      step('0, 0, 1, 2'd1, 16'hFFFF, 1);
      step('0, 0, 1, 2'd2, 16'hFFFF, 1);
      chk("R11 ignored", count_word, 16'h0000);
      step('0, 0, 1, 2'd3, 16'hFFFF, 1);
      step('0, 1, 0, 2'd3, '0, 1);
      // R7 rollover of nibble 0 with rollover irq enabled
      for (int i = 0; i < 16; i++) step(16'h0002, 0, 0, 2'd0, '0, 1);
      chk("R7 roll bit", {15'b0, status_word[12]}, 16'h0001);
      chk("R7 nibble wrapped", count_word, 16'h0000);
      chk("R9 roll irq", {15'b0, evt_irq}, 16'h0001);
      step('0, 1, 0, 2'd1, '0, 1);
      chk("R7 survives status read", {15'b0, status_word[12]}, 16'h0001);
      // R8 read clears, same-cycle increment lost
      step(16'h0884, 0, 0, 2'd0, '0, 1);
      chk("R6 nibbles", count_word, 16'h1110);
      step(16'h0002, 1, 0, 2'd2, '0, 1);
      chk("R8 clear", count_word, 16'h0000);
      chk("R8 roll clear", {15'b0, status_word[12]}, 16'h0000);
      // R10 link loss and acknowledge
      idle(0);
      chk("R10 pending irq", {15'b0, evt_irq}, 16'h0001);
      step('0, 0, 1, 2'd3, 16'h0040, 0);
      step('0, 0, 1, 2'd3, 16'h00E0, 0);
      chk("R10 acked", {15'b0, evt_irq}, 16'h0000);

      // constrained random phase
      for (int n = 0; n < 4000; n++) begin
         e  = 16'($urandom & $urandom & $urandom);
         rd = ($urandom % 5) == 0;
         wr = !rd && (($urandom % 7) == 0);
         a  = 2'($urandom);
         wd = 16'($urandom);
         lk = (($urandom % 13) == 0) ? !link_ok : link_ok;
         step(e, rd, wr, a, wd, lk);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule